// File: doc/BRIEF.md
# Interrupt Request Capture Front End

This block sits between the raw request wires of an interrupt controller and its priority logic. It turns the level on each wire into one bit of a request vector. A per-line trigger-kind input selects the rule for that line. A line in level mode makes its request bit follow the wire. A line in edge mode latches a request when the wire goes from low to high, and holds that request until it is acknowledged.

The priority logic acknowledges a line with a single-cycle strobe and the binary number of the line. The acknowledge clears only requests that were latched on an edge. A controller initialization strobe empties the request vector and the stored previous levels. The trigger-kind vector is an input, so initialization does not change it.

The raw wires are taken to be synchronous to the block clock and are sampled once per clock edge. Every result appears in the request vector one clock after the inputs that caused it.

Top module: `irq_capture`

## Requirements
- R1: With `trig_level[i]`=1 (level mode) and no init, `irq_req[i]` after an edge equals `irq_raw[i]` sampled at that edge.
- R2: With `trig_level[i]`=0 (edge mode), `irq_req[i]` is set after an edge where `irq_raw[i]` is high and the previously stored level of that line is low.
- R3: In edge mode a set request bit stays set when the wire falls or stays high, until it is acknowledged; a wire held high does not set the bit again.
- R4: An acknowledge (`ack_vld`=1, `ack_idx` = binary line number) on an edge-mode line clears its request bit when no new rising edge arrives in that cycle.
- R5: An acknowledge of a level-mode line has no effect; its bit keeps following the wire.
- R6: When a rising edge and an acknowledge of the same edge-mode line fall in the same cycle, the request bit is set.
- R7: `init_clr`=1 clears every request bit and every stored previous level on the next edge. An edge-mode line that is still high afterwards is captured again as a new edge.
- R8: After reset the request vector is all zero.
- R9: An acknowledge changes no line other than the one that `ack_idx` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_clr | input | 1 | Controller initialization strobe |
| irq_raw | input | NUM_LINES | Raw request wires |
| trig_level | input | NUM_LINES | Per-line trigger kind, 1 = level, 0 = edge |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Binary number of the acknowledged line |
| irq_req | output | NUM_LINES | Registered request vector |

## Verification
The bench builds the block with its default of eight lines. With eight lines the acknowledge index uses all three of its bits, and both end lines (0 and 7) can be placed in either trigger mode. The bench sets the upper half of the lines to level mode and the lower half to edge mode. Under that split an acknowledge, a same-cycle edge and an initialization can each hit lines of both kinds in one test sequence, and the bench checks lines that share a cycle against each other.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

  // Trigger kind of one request line, as carried on trig_level.
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_kind_e;

  // State held for each line.
  typedef struct packed {
    logic req;   // pending request
    logic prev;  // wire level seen at the last sample
  } line_state_t;

  localparam line_state_t LINE_IDLE = '{req: 1'b0, prev: 1'b0};

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // Assertion takes effect at once; release passes through the chain.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irq_ack_dec.sv
module irq_ack_dec #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 ack_vld,
  input  logic [IDX_W-1:0]     ack_idx,
  output logic [NUM_LINES-1:0] ack_hit
);

  // One-hot decode. An index with no line behind it selects nothing.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_hit
    assign ack_hit[g] = ack_vld && (ack_idx == IDX_W'(g));
  end

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_clr,
  input  logic       raw_in,
  input  trig_kind_e kind,
  input  logic       ack_hit,
  output logic       req_out
);

  line_state_t st_q;
  line_state_t st_d;
  logic        st_en;
  logic        rise;

  always_comb begin
    rise = raw_in && !st_q.prev;
    st_d = st_q;
    if (init_clr) begin
      st_d = LINE_IDLE;
    end else if (kind == TRIG_LEVEL) begin
      st_d.req  = raw_in;
      st_d.prev = raw_in;
    end else begin
      // A new edge beats an acknowledge in the same cycle.
      st_d.req  = rise || (st_q.req && !ack_hit);
      st_d.prev = raw_in;
    end
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LINE_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign req_out = st_q.req;

endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_cap_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_clr,
  input  logic [NUM_LINES-1:0] irq_raw,
  input  logic [NUM_LINES-1:0] trig_level,
  input  logic                 ack_vld,
  input  logic [IDX_W-1:0]     ack_idx,
  output logic [NUM_LINES-1:0] irq_req
);

  logic                 rst_core_n;
  logic [NUM_LINES-1:0] ack_hit;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_core_n)
  );

  irq_ack_dec #(.NUM_LINES(NUM_LINES)) u_dec (
    .ack_vld (ack_vld),
    .ack_idx (ack_idx),
    .ack_hit (ack_hit)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .init_clr (init_clr),
      .raw_in   (irq_raw[g]),
      .kind     (trig_kind_e'(trig_level[g])),
      .ack_hit  (ack_hit[g]),
      .req_out  (irq_req[g])
    );
  end

endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rst_core_n,
  input logic                 init_clr,
  input logic [NUM_LINES-1:0] irq_raw,
  input logic [NUM_LINES-1:0] trig_level,
  input logic                 ack_vld,
  input logic [IDX_W-1:0]     ack_idx,
  input logic [NUM_LINES-1:0] irq_req
);

  // Counts clock edges since reset release, stopping at 2.
  logic [1:0] hist_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      hist_q <= 2'd0;
    end else if (hist_q != 2'd2) begin
      hist_q <= hist_q + 2'd1;
    end
  end

  // R7
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (hist_q != 2'd0) && $past(init_clr) |-> (irq_req == '0));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    // R1
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      (hist_q != 2'd0) && $past(!init_clr && trig_level[g])
      |-> (irq_req[g] == $past(irq_raw[g])));

    // R2
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      (hist_q == 2'd2) && $past(!init_clr && !trig_level[g] && irq_raw[g])
      && !$past(irq_raw[g], 2) |-> irq_req[g]);

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      (hist_q != 2'd0) && $past(!init_clr && !trig_level[g] && irq_req[g]
      && !(ack_vld && ack_idx == IDX_W'(g))) |-> irq_req[g]);

    // R4
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      (hist_q != 2'd0) && $past(!init_clr && !trig_level[g] && !irq_raw[g]
      && ack_vld && ack_idx == IDX_W'(g)) |-> !irq_req[g]);

    // R5
    level_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      (hist_q != 2'd0) && $past(!init_clr && trig_level[g] && irq_raw[g]
      && ack_vld && ack_idx == IDX_W'(g)) |-> irq_req[g]);

    // R6
    edge_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      (hist_q == 2'd2) && $past(!init_clr && !trig_level[g] && irq_raw[g]
      && ack_vld && ack_idx == IDX_W'(g)) && !$past(irq_raw[g], 2) |-> irq_req[g]);

    // R9
    ack_other_line_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      (hist_q != 2'd0) && $past(!init_clr && !trig_level[g] && irq_req[g]
      && ack_vld && ack_idx != IDX_W'(g)) |-> irq_req[g]);
  end

endmodule

bind irq_capture irq_capture_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .init_clr   (init_clr),
  .irq_raw    (irq_raw),
  .trig_level (trig_level),
  .ack_vld    (ack_vld),
  .ack_idx    (ack_idx),
  .irq_req    (irq_req)
);

// File: tb/irq_capture_test.sv
`timescale 1ns/1ps
module irq_capture_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_clr = 1'b0;
  logic [7:0] irq_raw = '0;
  logic [7:0] trig_level = '0;
  logic       ack_vld = 1'b0;
  logic [2:0] ack_idx = '0;
  logic [7:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;  // 250 MHz

  irq_capture #(.NUM_LINES(8)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_clr   (init_clr),
    .irq_raw    (irq_raw),
    .trig_level (trig_level),
    .ack_vld    (ack_vld),
    .ack_idx    (ack_idx),
    .irq_req    (irq_req)
  );

  // Monitor: one expected item per clock, compared 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (irq_req !== e) begin
        errors++;
        $display("FAIL %s: irq_req=%02h expected=%02h", t, irq_req, e);
      end
    end
  end

  // Driver: applies inputs for one clock and queues the expected result.
  task automatic drive(input logic [7:0] l, input logic [7:0] m, input logic a,
                       input logic [2:0] ix, input logic ini,
                       input logic [7:0] e, input string tag);
    @(negedge clk);
    irq_raw    = l;
    trig_level = m;
    ack_vld    = a;
    ack_idx    = ix;
    init_clr   = ini;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (irq_req !== 8'h00) begin
      errors++;
      $display("FAIL R8: irq_req=%02h expected=00", irq_req);
    end
    // Upper four lines level mode, lower four edge mode.
    drive(8'h01, 8'hF0, 0, 3'd0, 0, 8'h01, "R2 rise line0");
    drive(8'h01, 8'hF0, 0, 3'd0, 0, 8'h01, "R3 held high");
    drive(8'h00, 8'hF0, 0, 3'd0, 0, 8'h01, "R3 fall keeps request");
    drive(8'h00, 8'hF0, 1, 3'd0, 0, 8'h00, "R4 ack clears line0");
    drive(8'h01, 8'hF0, 0, 3'd0, 0, 8'h01, "R2 second rise");
    drive(8'h01, 8'hF0, 1, 3'd0, 0, 8'h00, "R4 ack with steady high");
    drive(8'h01, 8'hF0, 0, 3'd0, 0, 8'h00, "R3 steady high no re-set");
    drive(8'h10, 8'hF0, 0, 3'd0, 0, 8'h10, "R1 level line4 high");
    drive(8'h10, 8'hF0, 1, 3'd4, 0, 8'h10, "R5 ack level line4");
    drive(8'h00, 8'hF0, 0, 3'd0, 0, 8'h00, "R1 level line4 low");
    drive(8'h08, 8'hF0, 1, 3'd3, 0, 8'h08, "R6 rise and ack line3");
    drive(8'h88, 8'hF0, 1, 3'd7, 0, 8'h88, "R5 ack level line7");
    drive(8'h80, 8'hF0, 1, 3'd3, 0, 8'h80, "R4 ack clears line3");
    drive(8'h83, 8'hF0, 0, 3'd0, 0, 8'h83, "R2 rise lines0,1");
    drive(8'h83, 8'hF0, 1, 3'd1, 0, 8'h81, "R9 ack line1 only");
    drive(8'h83, 8'hF0, 1, 3'd2, 0, 8'h81, "R9 ack idle line2");
    drive(8'h83, 8'hF0, 0, 3'd0, 1, 8'h00, "R7 init clears");
    drive(8'h83, 8'hF0, 0, 3'd0, 0, 8'h83, "R7 high line re-captured");
    drive(8'h03, 8'hFF, 0, 3'd0, 0, 8'h03, "R1 all level follow");
    drive(8'h00, 8'hFF, 0, 3'd0, 0, 8'h00, "R1 all level low");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule